// File: doc/BRIEF.md
# Page-Burst Stream Memory Scheduler

This block moves streaming data between two host-facing FIFOs and a page-oriented external memory. It never serves single-word accesses. It only moves whole pages. An inbound page is written to memory once the inbound FIFO holds a full page of words. A page is read back into the outbound FIFO once that FIFO has room for a full page. Between bursts it inserts the periodic refresh operations that the memory needs. The write stream and the read stream each keep their own page counter. A counter steps by one after every completed burst and wraps at a configurable page count.

The FIFO occupancy and free-space counts reach the block already synchronized into the memory clock domain, since the host side runs on a slower clock. Toward the memory, the block raises a request that carries a command code and a page number, and holds it until the memory acknowledges. After an acknowledged burst command, the memory presents one strobe per accepted data word. The block forwards each of these strobes as a pop of the inbound FIFO or a push into the outbound FIFO.

Top module: `page_stream_sched`

## Requirements
- R1: Every burst carries exactly PAGE_WORDS beats. Each memory beat produces exactly one in_pop during a write burst and exactly one out_push during a read burst. in_pop and out_push are never high together, and neither is high outside a burst.
- R2: A write burst is requested only if in_level was at least PAGE_WORDS on the clock edge where the request was decided.
- R3: A read burst is requested only if out_free was at least PAGE_WORDS and in_level was below PAGE_WORDS on the deciding edge, because writes take precedence over reads.
- R4: An internal timer raises a refresh request every REFRESH_PERIOD clocks. The request stays pending until it is acknowledged. A pending refresh wins over both burst kinds at the next idle point and never cuts a burst short. The first refresh request appears about REFRESH_PERIOD clocks after reset. The gap between two refreshes never exceeds REFRESH_PERIOD plus one burst duration.
- R5: After each completed burst, the page number for that direction advances by one and wraps to 0 after PAGE_COUNT-1. The other direction's page number is unchanged.
- R6: A synchronous reset, or a one-cycle restart pulse, sets both page numbers to 0. The next write burst and the next read burst therefore both address page 0.
- R7: mem_req stays high with a stable mem_cmd and mem_page until mem_ack. mem_cmd reads 2'b01 for a write, 2'b10 for a read, 2'b11 for a refresh and 2'b00 when no request is pending. busy is high from the grant until the refresh is acknowledged or the last beat of the burst. A new request is only raised after a cycle with busy low.
- R8: During write beats, mem_wdata equals in_data. During read beats, out_data equals mem_rdata. A stream written in therefore comes back out unchanged and in order.
- R9: During reset, busy, mem_req, in_pop and out_push are low and mem_cmd is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | One-cycle pulse that rewinds both page numbers to 0 |
| in_level | input | LVL_W | Words held in the inbound FIFO (synchronized) |
| in_data | input | DATA_W | Head word of the inbound FIFO (first-word fall-through) |
| in_pop | output | 1 | Pops one word from the inbound FIFO |
| out_free | input | LVL_W | Free slots in the outbound FIFO (synchronized) |
| out_data | output | DATA_W | Word pushed into the outbound FIFO |
| out_push | output | 1 | Pushes one word into the outbound FIFO |
| mem_req | output | 1 | Command request toward the memory |
| mem_cmd | output | 2 | Command code: 01 write, 10 read, 11 refresh, 00 none |
| mem_page | output | PG_W | Page number for the requested burst |
| mem_ack | input | 1 | Memory accepts the pending request |
| mem_beat | input | 1 | One data word accepted or delivered by the memory |
| mem_wdata | output | DATA_W | Write data toward the memory |
| mem_rdata | input | DATA_W | Read data from the memory |
| busy | output | 1 | High from grant until the operation completes |

## Verification
The request is registered. It appears one clock after the edge on which the thresholds and the refresh flag were sampled. The bench therefore judges every new request against the input values it drove in the cycle before it saw mem_req rise. The strobes and data forwarding are combinational on each beat, so they are compared in the same cycle as the beat, just before the edge that consumes them. busy and the page numbers settle on the edge after the last beat, so busy is checked one cycle after each burst ends. Each page number is checked when the next burst of that direction is acknowledged. Refresh timing is measured between acknowledgements against a window of one refresh period plus the longest burst.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;

  // Command codes seen by the memory on mem_cmd
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_READ    = 2'd2,
    CMD_REFRESH = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } state_e;

  // True when a FIFO count covers one whole page
  function automatic logic covers_page(input int unsigned amount,
                                       input int unsigned page_words);
    return amount >= page_words;
  endfunction

  // Page number after a completed burst, wrapping at the page count
  function automatic int unsigned page_after(input int unsigned page,
                                             input int unsigned count);
    return (page + 1 >= count) ? 0 : page + 1;
  endfunction

  // Fixed priority: refresh, then write, then read
  function automatic cmd_e pick_cmd(input logic ref_pend,
                                    input logic wr_ok,
                                    input logic rd_ok);
    if (ref_pend)   return CMD_REFRESH;
    else if (wr_ok) return CMD_WRITE;
    else if (rd_ok) return CMD_READ;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/pss_refresh_timer.sv
`timescale 1ns/1ps
module pss_refresh_timer #(
  parameter int unsigned PERIOD = 780,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic service,
  output logic pending
);
  logic [CNT_W-1:0] count;
  logic             tick;

  assign tick = (count == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      pending <= 1'b0;
    end else begin
      count   <= tick ? '0 : count + 1'b1;
      pending <= (pending & ~service) | tick;
    end
  end
endmodule

// File: rtl/pss_page_ctr.sv
`timescale 1ns/1ps
module pss_page_ctr
  import pss_pkg::*;
#(
  parameter int unsigned PAGE_COUNT = 1024,
  parameter int unsigned PG_W       = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            advance,
  output logic [PG_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst || restart) page <= '0;
    else if (advance)   page <= PG_W'(page_after(32'(page), PAGE_COUNT));
  end
endmodule

// File: rtl/pss_beat_ctr.sv
`timescale 1ns/1ps
module pss_beat_ctr #(
  parameter int unsigned PAGE_WORDS = 512,
  localparam int unsigned BC_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  output logic last
);
  logic [BC_W-1:0] idx;

  assign last = beat && (idx == BC_W'(PAGE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (last) idx <= '0;
    else if (beat) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/pss_arbiter.sv
`timescale 1ns/1ps
module pss_arbiter
  import pss_pkg::*;
(
  input  logic idle,
  input  logic ref_pend,
  input  logic wr_ok,
  input  logic rd_ok,
  output cmd_e grant
);
  always_comb begin
    grant = CMD_NONE;
    if (idle) grant = pick_cmd(ref_pend, wr_ok, rd_ok);
  end
endmodule

// File: rtl/page_stream_sched.sv
`timescale 1ns/1ps
module page_stream_sched
  import pss_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned PAGE_WORDS     = 512,
  parameter int unsigned PAGE_COUNT     = 1024,
  parameter int unsigned REFRESH_PERIOD = 780,
  parameter int unsigned LVL_W          = 12,
  localparam int unsigned PG_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [LVL_W-1:0]  in_level,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_pop,
  input  logic [LVL_W-1:0]  out_free,
  output logic [DATA_W-1:0] out_data,
  output logic              out_push,
  output logic              mem_req,
  output logic [1:0]        mem_cmd,
  output logic [PG_W-1:0]   mem_page,
  input  logic              mem_ack,
  input  logic              mem_beat,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy
);
  state_e state;
  cmd_e   cur_cmd;
  cmd_e   grant_cmd;

  // Named internal events, also observed by the bound checker
  logic ref_pend, ref_service;
  logic wr_ok, rd_ok;
  logic xfer_beat, burst_last;
  logic wr_done, rd_done;
  logic [1:0]           dir_adv;
  logic [1:0][PG_W-1:0] dir_page;
  logic [PG_W-1:0]      wr_page, rd_page;

  assign wr_ok = covers_page(32'(in_level), PAGE_WORDS);
  assign rd_ok = covers_page(32'(out_free), PAGE_WORDS);

  pss_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_refresh (
    .clk(clk), .rst(rst), .service(ref_service), .pending(ref_pend)
  );

  pss_arbiter u_arb (
    .idle(state == ST_IDLE), .ref_pend(ref_pend),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .grant(grant_cmd)
  );

  pss_beat_ctr #(.PAGE_WORDS(PAGE_WORDS)) u_beats (
    .clk(clk), .rst(rst), .beat(xfer_beat), .last(burst_last)
  );

  // One page counter per direction: index 0 write, index 1 read
  for (genvar d = 0; d < 2; d++) begin : g_dir
    pss_page_ctr #(.PAGE_COUNT(PAGE_COUNT), .PG_W(PG_W)) u_page (
      .clk(clk), .rst(rst), .restart(restart),
      .advance(dir_adv[d]), .page(dir_page[d])
    );
  end

  assign wr_page = dir_page[0];
  assign rd_page = dir_page[1];

  assign xfer_beat   = (state == ST_XFER) && mem_beat;
  assign wr_done     = burst_last && (cur_cmd == CMD_WRITE);
  assign rd_done     = burst_last && (cur_cmd == CMD_READ);
  assign dir_adv     = {rd_done, wr_done};
  assign ref_service = (state == ST_REQ) && (cur_cmd == CMD_REFRESH) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur_cmd <= CMD_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (grant_cmd != CMD_NONE) begin
          state   <= ST_REQ;
          cur_cmd <= grant_cmd;
        end
        ST_REQ: if (mem_ack) begin
          state <= (cur_cmd == CMD_REFRESH) ? ST_IDLE : ST_XFER;
        end
        ST_XFER: if (burst_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign mem_req  = (state == ST_REQ);
  assign mem_cmd  = mem_req ? cur_cmd : CMD_NONE;

  always_comb begin
    mem_page = '0;
    if (busy && cur_cmd == CMD_WRITE) mem_page = wr_page;
    if (busy && cur_cmd == CMD_READ)  mem_page = rd_page;
  end

  assign in_pop    = xfer_beat && (cur_cmd == CMD_WRITE);
  assign out_push  = xfer_beat && (cur_cmd == CMD_READ);
  assign mem_wdata = in_data;
  assign out_data  = mem_rdata;
endmodule

// File: rtl/pss_checker.sv
`timescale 1ns/1ps
module pss_checker
  import pss_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = 512,
  parameter int unsigned PAGE_COUNT = 1024,
  parameter int unsigned LVL_W      = 12,
  parameter int unsigned PG_W       = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic [LVL_W-1:0] in_level,
  input logic [LVL_W-1:0] out_free,
  input logic             mem_req,
  input logic [1:0]       mem_cmd,
  input logic [PG_W-1:0]  mem_page,
  input logic             mem_ack,
  input logic             busy,
  input logic             in_pop,
  input logic             out_push,
  input logic             ref_pend,
  input logic             ref_service,
  input logic             wr_done,
  input logic             rd_done,
  input logic [PG_W-1:0]  wr_page,
  input logic [PG_W-1:0]  rd_page
);
  // Independent beat tally since the last accepted command
  logic [31:0] seen;
  always_ff @(posedge clk) begin
    if (rst)                       seen <= '0;
    else if (mem_req && mem_ack)   seen <= '0;
    else if (in_pop || out_push)   seen <= seen + 1;
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    (wr_done || rd_done) |-> ((in_pop || out_push) && seen == PAGE_WORDS - 1)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_pop && out_push)); // R1
  AST_WR_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_cmd == CMD_WRITE) |-> 32'($past(in_level)) >= PAGE_WORDS); // R2
  AST_RD_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_cmd == CMD_READ) |->
      (32'($past(out_free)) >= PAGE_WORDS && 32'($past(in_level)) < PAGE_WORDS)); // R3
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_cmd != CMD_REFRESH) |-> !$past(ref_pend)); // R4
  AST_REF_HELD: assert property (@(posedge clk) disable iff (rst)
    (ref_pend && !ref_service) |=> ref_pend); // R4
  AST_WR_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !restart) |=> 32'(wr_page) == (32'($past(wr_page)) + 1) % PAGE_COUNT); // R5
  AST_RD_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !restart) |=> 32'(rd_page) == (32'($past(rd_page)) + 1) % PAGE_COUNT); // R5
  AST_WR_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !restart) |=> $stable(wr_page)); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (wr_page == '0 && rd_page == '0)); // R6
  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> !$past(busy)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_cmd) && $stable(mem_page))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !mem_req)); // R9
endmodule

bind page_stream_sched pss_checker #(
  .PAGE_WORDS(PAGE_WORDS), .PAGE_COUNT(PAGE_COUNT), .LVL_W(LVL_W), .PG_W(PG_W)
) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .in_level(in_level), .out_free(out_free),
  .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_page(mem_page), .mem_ack(mem_ack),
  .busy(busy), .in_pop(in_pop), .out_push(out_push), .ref_pend(ref_pend),
  .ref_service(ref_service), .wr_done(wr_done), .rd_done(rd_done),
  .wr_page(wr_page), .rd_page(rd_page)
);

// File: tb/page_stream_sched_tb.sv
`timescale 1ns/1ps
module page_stream_sched_tb;
  import pss_pkg::*;

  localparam int DW = 16, PW = 512, PC = 4, RP = 780, LW = 12, PGW = 2;
  localparam int ACK_LAT = 2, OUT_DEPTH = 1024;
  localparam int SLIP = PW + PW / 6 + ACK_LAT + 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, restart, in_pop, out_push, mem_req, mem_ack, mem_beat, busy;
  logic [LW-1:0]  in_level, out_free;
  logic [DW-1:0]  in_data, out_data, mem_wdata, mem_rdata;
  logic [1:0]     mem_cmd;
  logic [PGW-1:0] mem_page;

  page_stream_sched #(.DATA_W(DW), .PAGE_WORDS(PW), .PAGE_COUNT(PC),
                      .REFRESH_PERIOD(RP), .LVL_W(LW)) u_dut (
    .clk(clk), .rst(rst), .restart(restart), .in_level(in_level), .in_data(in_data),
    .in_pop(in_pop), .out_free(out_free), .out_data(out_data), .out_push(out_push),
    .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_page(mem_page), .mem_ack(mem_ack),
    .mem_beat(mem_beat), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // Behavioural model state: FIFOs as queues, memory as an array
  logic [DW-1:0] inq[$];
  logic [DW-1:0] outq[$];
  logic [DW-1:0] mem [0:PC*PW-1];
  int mstate = 0, lat = 0, bidx = 0, bpage = 0;
  logic [1:0] bcmd = 2'd0;
  int exp_wr_page = 0, exp_rd_page = 0;
  int wr_bursts = 0, rd_started = 0, rd_bursts = 0, ref_count = 0;
  longint last_ref = 0, t_release = 0;
  int prod_left = 0, seq_in = 0, seq_out = 0, data_err = 0, strobe_err = 0;
  bit cons_en = 0, done_pending = 0, restart_req = 0, after_restart = 0;
  logic prev_busy = 0, prev_req = 0;
  logic [LW-1:0] prev_level = '0, prev_free = '0;

  function automatic logic [DW-1:0] word_of(input int k);
    return DW'(k * 40503 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic step();
    longint gap;
    logic [DW-1:0] w;
    @(negedge clk);
    // host producer at roughly half the memory clock rate
    if (prod_left > 0 && cyc % 2 == 0) begin
      inq.push_back(word_of(seq_in)); seq_in++; prod_left--;
    end
    // host consumer, checks order and content (R8)
    if (cons_en && outq.size() > 0 && cyc % 3 != 0) begin
      w = outq.pop_front();
      if (w !== word_of(seq_out)) begin
        data_err++;
        $display("FAIL R8 word %0d actual=%0d expected=%0d", seq_out, w, word_of(seq_out));
      end
      seq_out++;
    end
    // drive inputs
    restart   = restart_req;
    if (restart_req) begin
      restart_req = 0; exp_wr_page = 0; exp_rd_page = 0; after_restart = 1;
    end
    in_level  = LW'(inq.size());
    in_data   = (inq.size() > 0) ? inq[0] : '0;
    out_free  = (rd_started < wr_bursts) ? LW'(OUT_DEPTH - outq.size()) : '0;
    if (mstate == 1 && lat > 0) lat--;
    mem_ack   = (mstate == 1 && lat == 0);
    mem_beat  = (mstate == 2 && bidx < PW && cyc % 7 != 3);
    mem_rdata = (mstate == 2 && bcmd == CMD_READ && bidx < PW) ? mem[bpage*PW + bidx] : '0;
    #0.5;
    // observe
    if (done_pending) begin
      chk(!busy && !mem_req, "R7 busy low after last beat", busy, 0);
      done_pending = 0;
    end
    if (mem_req && !prev_req) begin
      chk(!prev_busy, "R7 new request only after idle", prev_busy, 0);
      if (mem_cmd == CMD_WRITE)
        chk(prev_level >= PW, "R2 write threshold", prev_level, PW);
      else if (mem_cmd == CMD_READ)
        chk(prev_free >= PW && prev_level < PW, "R3 read threshold", prev_free, PW);
      mstate = 1; lat = ACK_LAT;
    end
    if (mem_req && mem_ack) begin
      if (mem_cmd == CMD_REFRESH) begin
        gap = cyc - last_ref;
        if (ref_count == 0)
          chk(gap >= RP && gap <= RP + ACK_LAT + 4, "R4 first refresh time", gap, RP);
        chk(gap <= RP + SLIP, "R4 refresh gap", gap, RP + SLIP);
        last_ref = cyc; ref_count++; mstate = 0;
      end else begin
        bcmd = mem_cmd; bpage = int'(mem_page); bidx = 0; mstate = 2;
        if (mem_cmd == CMD_WRITE) begin
          chk(int'(mem_page) == exp_wr_page, after_restart ? "R6 write page after restart"
                                                         : "R5 write page", mem_page, exp_wr_page);
          exp_wr_page = (exp_wr_page + 1) % PC;
        end else begin
          chk(int'(mem_page) == exp_rd_page, after_restart ? "R6 read page after restart"
                                                         : "R5 read page", mem_page, exp_rd_page);
          exp_rd_page = (exp_rd_page + 1) % PC;
          rd_started++;
        end
      end
    end
    if (mstate == 2 && mem_beat) begin
      if (bcmd == CMD_WRITE) begin
        if (!in_pop || out_push || inq.size() == 0) strobe_err++;
        else begin
          if (mem_wdata !== inq[0]) data_err++;
          mem[bpage*PW + bidx] = mem_wdata;
          void'(inq.pop_front());
        end
      end else begin
        if (!out_push || in_pop) strobe_err++;
        else begin
          if (out_data !== mem_rdata) data_err++;
          outq.push_back(out_data);
        end
      end
      bidx++;
      if (bidx == PW) begin
        mstate = 0; done_pending = 1;
        if (bcmd == CMD_WRITE) wr_bursts++; else rd_bursts++;
      end
    end else if (in_pop || out_push) strobe_err++;
    prev_busy = busy; prev_req = mem_req; prev_level = in_level; prev_free = out_free;
  endtask

  initial begin
    rst = 1; restart = 0; in_level = '0; in_data = '0; out_free = '0;
    mem_ack = 0; mem_beat = 0; mem_rdata = '0;
    fork
      forever step();
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 100000);
        finish_run();
      end
    join_none
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !mem_req && !in_pop && !out_push && mem_cmd == 2'd0,
        "R9 reset state", {busy, mem_req, in_pop, out_push}, 0);
    @(negedge clk);
    rst = 0; t_release = cyc; last_ref = cyc;

    // one word short of a page: only refreshes may occur
    prod_left = PW - 1;
    while (cyc < t_release + 1600) @(negedge clk);
    chk(wr_bursts == 0 && mstate != 2, "R2 no write below one page", wr_bursts, 0);
    chk(ref_count >= 1, "R4 refresh while idle", ref_count, 1);

    // fill all pages, then stream them back
    prod_left = 1 + 3 * PW; cons_en = 1;
    while (!(rd_bursts == 4 && seq_out == 4 * PW)) @(negedge clk);
    chk(data_err == 0, "R8 first four pages intact", data_err, 0);
    chk(strobe_err == 0, "R1 strobes match beats", strobe_err, 0);

    // two more pages wrap the page numbers
    prod_left = 2 * PW;
    while (!(rd_bursts == 6 && seq_out == 6 * PW)) @(negedge clk);
    chk(data_err == 0, "R8 wrapped pages intact", data_err, 0);
    chk(exp_wr_page == 2 && exp_rd_page == 2, "R5 wrap sequence", exp_wr_page, 2);

    // restart rewinds both page numbers
    repeat (3) @(negedge clk);
    restart_req = 1;
    repeat (3) @(negedge clk);
    prod_left = PW;
    while (!(rd_bursts == 7 && seq_out == 7 * PW)) @(negedge clk);
    chk(data_err == 0, "R8 data after restart", data_err, 0);
    chk(strobe_err == 0, "R1 strobes over whole run", strobe_err, 0);
    chk(ref_count >= int'((cyc - t_release) / RP) - 1, "R4 refresh count",
        ref_count, (cyc - t_release) / RP);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule